// File: doc/BRIEF.md
# Multi-Source CPU Reset Controller

This block merges every reason a small 4-bit-class microcontroller core may need to restart into one synchronous CPU reset. Four requests feed it: an active-low supply-good indication from an analog detector (covering both first power-up and a brief dip below the operating level), an active-low external reset pin, a comparator that watches the Port B pins for a build-time pattern, and an optional watchdog counter. The watchdog is kept quiet by read accesses to its bus address.

While reset is held, the block clears the interrupt-control state through a dedicated strobe and forces the peripheral I/O bus control lines to a fixed reset-mode encoding. Reset is stretched for a set number of machine cycles after the last request disappears. When it is released, the block substitutes a short-call opcode for the next instruction fetch, so the core enters its initialization routine at a fixed ROM vector. A small cause register tells the software which source triggered the most recent reset.

Top module: `cpu_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `cpu_rst` is high at once, without waiting for a clock edge. After `por_n` rises, `cpu_rst` stays high through two synchronizer edges plus `HOLD_CYC` further edges, and it falls after the sixth rising edge when the defaults apply.
- R2: A low level on `ext_rst_n` causes a reset only when it is seen low on at least `PIN_MIN_CYC` consecutive synchronized samples. A low pulse that lasts one cycle leaves `cpu_rst` low.
- R3: When the synchronized `portb_pin` value equals `RST_CODE`, a reset follows one edge later. No input masks it, and it fires whatever drives the pins. Any other pin value has no effect.
- R4: With `WDOG_EN` set, the watchdog counts once per cycle outside reset. After 2^`WDOG_W` counts without a clear, it raises a reset one edge later.
- R5: A watchdog read (`wd_acc`=1, `wd_wr`=0) clears the watchdog counter. A write (`wd_acc`=1, `wd_wr`=1) does not clear it.
- R6: After the last active request is sampled on an edge, `cpu_rst` stays high for exactly `HOLD_CYC` more edges and then falls.
- R7: While `cpu_rst` is high, `intc_clear` is high and `iobus_ctl` equals `IOCTL_RST`. While `cpu_rst` is low, `intc_clear` is low and `iobus_ctl` follows `cpu_ioctl`.
- R8: On the edge where `cpu_rst` falls, `inj_valid` rises. It then presents `instr`=0xC1 (`VEC_OPC`) and `inj_target`=0x008 (`VEC_ADDR`) until an edge that samples `cpu_fetch` high. After that edge `instr` follows `rom_data` and `inj_target` is 0.
- R9: `rst_cause` holds one bit per source: bit 0 power, bit 1 external pin, bit 2 port code, bit 3 watchdog. A power-on reset sets it to 4'b0001. Any other reset loads the set of requests active on the edge that started it, and bit 0 is then 0. The value persists after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine-cycle clock |
| por_n | input | 1 | Supply-good indication, low forces reset asynchronously |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| portb_pin | input | PORT_W | Port B pin levels, asynchronous |
| wd_acc | input | 1 | Bus access to the watchdog address in this cycle |
| wd_wr | input | 1 | Access direction: 1 write, 0 read |
| cpu_ioctl | input | IOCTL_W | I/O bus control from the core |
| rom_data | input | 8 | Instruction byte from program memory |
| cpu_fetch | input | 1 | Core consumes the presented instruction this cycle |
| cpu_rst | output | 1 | Synchronous CPU reset, active high |
| intc_clear | output | 1 | Clears interrupt enable, pending and active state |
| iobus_ctl | output | IOCTL_W | I/O bus control toward peripherals |
| instr | output | 8 | Instruction byte toward the core |
| inj_valid | output | 1 | Vector call is being injected |
| inj_target | output | ROM_AW | Call target while injecting, else 0 |
| rst_cause | output | 4 | Source of the last reset |

## Verification
The bench builds the block with `RST_CODE`=4'h5 instead of all zeros, so that resting high pins and a near-miss value of 4'h4 can be told apart from a real hit. `WDOG_W`=6 brings the watchdog overflow down to 64 cycles, which makes the expiry, the write-does-not-clear case and the mid-count read clear all reachable with exact cycle counts. `PIN_MIN_CYC`=2 and `HOLD_CYC`=4 keep the defaults, so the one-cycle and two-cycle pin pulses sit right at the filter boundary, and every release edge can be checked on the exact cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

   localparam int CAUSE_W   = 4;
   localparam int CAUSE_POR = 0;
   localparam int CAUSE_PIN = 1;
   localparam int CAUSE_CODE = 2;
   localparam int CAUSE_WDOG = 3;

   typedef logic [CAUSE_W-1:0] cause_t;

   localparam logic [7:0]  SCALL_OPC  = 8'hC1;
   localparam int          RST_VECTOR = 8;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int            W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage0;
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         stage0 <= RST_VAL;
         stage1 <= RST_VAL;
      end else begin
         stage0 <= d;
         stage1 <= stage0;
      end
   end

   assign q = stage1;

endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
   parameter int MIN_CYC = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_low,
   output logic req
);

   generate
      if (MIN_CYC <= 1) begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ arst_n;
         assign req = pin_low;
      end else begin : g_count
         localparam int CW = $clog2(MIN_CYC);
         localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);
         logic [CW-1:0] run;

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)
               run <= '0;
            else if (!pin_low)
               run <= '0;
            else if (run != LAST)
               run <= run + 1'b1;
         end

         assign req = pin_low && (run == LAST);
      end
   endgenerate

endmodule

// File: rtl/rstc_watchdog.sv
module rstc_watchdog #(
   parameter bit EN = 1'b1,
   parameter int W  = 12
) (
   input  logic clk,
   input  logic arst_n,
   input  logic hold,
   input  logic rd_clr,
   output logic ovf
);

   generate
      if (EN) begin : g_on
         logic [W-1:0] cnt;
         logic         ovf_q;

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               cnt   <= '0;
               ovf_q <= 1'b0;
            end else if (hold || rd_clr) begin
               cnt   <= '0;
               ovf_q <= 1'b0;
            end else begin
               cnt   <= cnt + 1'b1;
               ovf_q <= &cnt;
            end
         end

         assign ovf = ovf_q;
      end else begin : g_off
         logic unused_in;
         assign unused_in = clk ^ arst_n ^ hold ^ rd_clr;
         assign ovf = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cpu_reset_ctrl.sv
module cpu_reset_ctrl
   import rstc_pkg::*;
#(
   parameter int                 PORT_W      = 4,
   parameter logic [PORT_W-1:0]  RST_CODE    = '0,
   parameter int                 PIN_MIN_CYC = 2,
   parameter int                 HOLD_CYC    = 4,
   parameter bit                 WDOG_EN     = 1'b1,
   parameter int                 WDOG_W      = 12,
   parameter int                 IOCTL_W     = 3,
   parameter logic [IOCTL_W-1:0] IOCTL_RST   = '1,
   parameter int                 ROM_AW      = 12,
   parameter logic [ROM_AW-1:0]  VEC_ADDR    = ROM_AW'(RST_VECTOR),
   parameter logic [7:0]         VEC_OPC     = SCALL_OPC
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               ext_rst_n,
   input  logic [PORT_W-1:0]  portb_pin,
   input  logic               wd_acc,
   input  logic               wd_wr,
   input  logic [IOCTL_W-1:0] cpu_ioctl,
   input  logic [7:0]         rom_data,
   input  logic               cpu_fetch,
   output logic               cpu_rst,
   output logic               intc_clear,
   output logic [IOCTL_W-1:0] iobus_ctl,
   output logic [7:0]         instr,
   output logic               inj_valid,
   output logic [ROM_AW-1:0]  inj_target,
   output logic [CAUSE_W-1:0] rst_cause
);

   localparam int HOLD_W = $clog2(HOLD_CYC + 1);
   localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC);

   // elaboration-time parameter checks
   generate
      if (PORT_W < 1) begin : g_bad_port
         $error("PORT_W must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (PIN_MIN_CYC < 1) begin : g_bad_pin
         $error("PIN_MIN_CYC must be at least 1");
      end
      if (WDOG_W < 2) begin : g_bad_wdog
         $error("WDOG_W must be at least 2");
      end
      if (ROM_AW < 4) begin : g_bad_rom
         $error("ROM_AW must be at least 4");
      end
   endgenerate

   // power request: asserted asynchronously, released through two flops
   logic [1:0] por_pipe;
   logic       por_rst;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         por_pipe <= 2'b00;
      else
         por_pipe <= {por_pipe[0], 1'b1};
   end

   assign por_rst = ~por_pipe[1];

   // external pin path
   logic ext_sync;
   logic pin_req;

   rstc_sync #(.W(1), .RST_VAL(1'b1)) u_ext_sync (
      .clk    (clk),
      .arst_n (por_n),
      .d      (ext_rst_n),
      .q      (ext_sync)
   );

   rstc_pin_filter #(.MIN_CYC(PIN_MIN_CYC)) u_pin_filt (
      .clk     (clk),
      .arst_n  (por_n),
      .pin_low (~ext_sync),
      .req     (pin_req)
   );

   // port pattern path
   logic [PORT_W-1:0] portb_sync;
   logic              code_req;

   rstc_sync #(.W(PORT_W), .RST_VAL(~RST_CODE)) u_portb_sync (
      .clk    (clk),
      .arst_n (por_n),
      .d      (portb_pin),
      .q      (portb_sync)
   );

   assign code_req = (portb_sync == RST_CODE);

   // watchdog
   logic rst_q;
   logic wd_ovf;

   rstc_watchdog #(.EN(WDOG_EN), .W(WDOG_W)) u_wdog (
      .clk    (clk),
      .arst_n (por_n),
      .hold   (rst_q),
      .rd_clr (wd_acc & ~wd_wr),
      .ovf    (wd_ovf)
   );

   // request merge and stretch
   logic              any_req;
   logic [HOLD_W-1:0] hold_cnt;
   logic [HOLD_W-1:0] hold_nxt;
   logic              rst_nxt;

   assign any_req = por_rst | pin_req | code_req | wd_ovf;

   always_comb begin
      if (any_req) begin
         hold_nxt = HOLD_LOAD;
         rst_nxt  = 1'b1;
      end else if (hold_cnt > HOLD_W'(1)) begin
         hold_nxt = hold_cnt - 1'b1;
         rst_nxt  = 1'b1;
      end else begin
         hold_nxt = '0;
         rst_nxt  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hold_cnt <= HOLD_LOAD;
         rst_q    <= 1'b1;
      end else begin
         hold_cnt <= hold_nxt;
         rst_q    <= rst_nxt;
      end
   end

   // cause register
   cause_t cause_q;
   cause_t cause_new;

   always_comb begin
      cause_new             = '0;
      cause_new[CAUSE_PIN]  = pin_req;
      cause_new[CAUSE_CODE] = code_req;
      cause_new[CAUSE_WDOG] = wd_ovf;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cause_q <= cause_t'(1) << CAUSE_POR;
      else if (por_rst)
         cause_q <= cause_t'(1) << CAUSE_POR;
      else if (any_req && !rst_q)
         cause_q <= cause_new;
   end

   // vector injection after release
   logic inj_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         inj_q <= 1'b0;
      else if (rst_nxt)
         inj_q <= 1'b0;
      else if (rst_q)
         inj_q <= 1'b1;
      else if (cpu_fetch)
         inj_q <= 1'b0;
   end

   assign cpu_rst    = rst_q;
   assign intc_clear = rst_q;
   assign iobus_ctl  = rst_q ? IOCTL_RST : cpu_ioctl;
   assign instr      = inj_q ? VEC_OPC : rom_data;
   assign inj_valid  = inj_q;
   assign inj_target = inj_q ? VEC_ADDR : '0;
   assign rst_cause  = cause_q;

endmodule

// File: rtl/cpu_reset_ctrl_chk.sv
module cpu_reset_ctrl_chk #(
   parameter int         HOLD_CYC = 4,
   parameter logic [7:0] VEC_OPC  = 8'hC1
) (
   input logic       clk,
   input logic       por_n,
   input logic       pin_req,
   input logic       code_req,
   input logic       wd_ovf,
   input logic       any_req,
   input logic       wd_acc,
   input logic       wd_wr,
   input logic       cpu_rst,
   input logic       inj_valid,
   input logic [7:0] instr
);

   localparam int QW = $clog2(HOLD_CYC + 2);
   localparam logic [QW-1:0] QMAX = QW'(HOLD_CYC + 1);

   // cycles since the last merged request, saturating
   logic [QW-1:0] quiet;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         quiet <= '0;
      else if (any_req)
         quiet <= '0;
      else if (quiet != QMAX)
         quiet <= quiet + 1'b1;
   end

   a_r2_pin_resets: assert property (@(posedge clk) disable iff (!por_n)
      pin_req |=> cpu_rst);

   a_r3_code_resets: assert property (@(posedge clk) disable iff (!por_n)
      code_req |=> cpu_rst);

   a_r4_wdog_resets: assert property (@(posedge clk) disable iff (!por_n)
      wd_ovf |=> cpu_rst);

   a_r5_read_clears: assert property (@(posedge clk) disable iff (!por_n)
      (wd_acc && !wd_wr) |=> !wd_ovf);

   a_r6_hold_length: assert property (@(posedge clk) disable iff (!por_n)
      $fell(cpu_rst) |-> (quiet == QW'(HOLD_CYC)));

   a_r8_vector_on_release: assert property (@(posedge clk) disable iff (!por_n)
      $fell(cpu_rst) |-> (inj_valid && instr == VEC_OPC));

endmodule

bind cpu_reset_ctrl cpu_reset_ctrl_chk #(
   .HOLD_CYC (HOLD_CYC),
   .VEC_OPC  (VEC_OPC)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .pin_req   (pin_req),
   .code_req  (code_req),
   .wd_ovf    (wd_ovf),
   .any_req   (any_req),
   .wd_acc    (wd_acc),
   .wd_wr     (wd_wr),
   .cpu_rst   (cpu_rst),
   .inj_valid (inj_valid),
   .instr     (instr)
);

// File: tb/tb_cpu_reset_ctrl.sv
module tb_cpu_reset_ctrl;

   localparam int         PORT_W  = 4;
   localparam logic [3:0] CODE    = 4'h5;
   localparam logic [3:0] IDLE_PB = 4'hF;
   localparam logic [2:0] CTL_RST = 3'b101;
   localparam logic [2:0] CTL_RUN = 3'b010;
   localparam logic [7:0] ROMBYTE = 8'h3A;

   logic        clk = 1'b0;
   logic        por_n;
   logic        ext_rst_n;
   logic [3:0]  portb_pin;
   logic        wd_acc;
   logic        wd_wr;
   logic [2:0]  cpu_ioctl;
   logic [7:0]  rom_data;
   logic        cpu_fetch;
   logic        cpu_rst;
   logic        intc_clear;
   logic [2:0]  iobus_ctl;
   logic [7:0]  instr;
   logic        inj_valid;
   logic [11:0] inj_target;
   logic [3:0]  rst_cause;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   cpu_reset_ctrl #(
      .PORT_W      (PORT_W),
      .RST_CODE    (CODE),
      .PIN_MIN_CYC (2),
      .HOLD_CYC    (4),
      .WDOG_EN     (1'b1),
      .WDOG_W      (6),
      .IOCTL_W     (3),
      .IOCTL_RST   (CTL_RST),
      .ROM_AW      (12)
   ) dut (
      .clk        (clk),
      .por_n      (por_n),
      .ext_rst_n  (ext_rst_n),
      .portb_pin  (portb_pin),
      .wd_acc     (wd_acc),
      .wd_wr      (wd_wr),
      .cpu_ioctl  (cpu_ioctl),
      .rom_data   (rom_data),
      .cpu_fetch  (cpu_fetch),
      .cpu_rst    (cpu_rst),
      .intc_clear (intc_clear),
      .iobus_ctl  (iobus_ctl),
      .instr      (instr),
      .inj_valid  (inj_valid),
      .inj_target (inj_target),
      .rst_cause  (rst_cause)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // called right after the edge on which cpu_rst has fallen
   task automatic release_checks(input string src);
      chk({"R6 release ", src}, 32'(cpu_rst), 32'd0);
      chk({"R7 intc_clear after ", src}, 32'(intc_clear), 32'd0);
      chk({"R7 iobus_ctl after ", src}, 32'(iobus_ctl), 32'(CTL_RUN));
      chk({"R8 inj_valid after ", src}, 32'(inj_valid), 32'd1);
      chk({"R8 opcode after ", src}, 32'(instr), 32'hC1);
      chk({"R8 target after ", src}, 32'(inj_target), 32'h008);
      step(2);
      chk({"R8 held without fetch ", src}, 32'(instr), 32'hC1);
      cpu_fetch = 1'b1;
      step(1);
      cpu_fetch = 1'b0;
      chk({"R8 inj ends ", src}, 32'(inj_valid), 32'd0);
      chk({"R8 rom passes ", src}, 32'(instr), 32'(ROMBYTE));
      chk({"R8 target idle ", src}, 32'(inj_target), 32'd0);
   endtask

   task automatic t_power_on();
      step(3);
      chk("R1 rst during por", 32'(cpu_rst), 32'd1);
      chk("R7 intc_clear in reset", 32'(intc_clear), 32'd1);
      chk("R7 iobus reset mode", 32'(iobus_ctl), 32'(CTL_RST));
      chk("R9 cause after por", 32'(rst_cause), 32'h1);
      por_n = 1'b1;
      step(5);
      chk("R1 still held", 32'(cpu_rst), 32'd1);
      step(1);
      release_checks("por");
      chk("R9 cause por kept", 32'(rst_cause), 32'h1);
   endtask

   task automatic t_pin_long();
      ext_rst_n = 1'b0;
      step(2);
      ext_rst_n = 1'b1;
      step(1);
      chk("R2 not yet", 32'(cpu_rst), 32'd0);
      step(1);
      chk("R2 two-cycle low resets", 32'(cpu_rst), 32'd1);
      chk("R9 cause pin", 32'(rst_cause), 32'h2);
      step(3);
      chk("R6 hold pin", 32'(cpu_rst), 32'd1);
      step(1);
      release_checks("pin");
   endtask

   task automatic t_pin_short();
      ext_rst_n = 1'b0;
      step(1);
      ext_rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step(1);
         chk("R2 short pulse ignored", 32'(cpu_rst), 32'd0);
      end
      chk("R2 cause untouched", 32'(rst_cause), 32'h2);
   endtask

   task automatic t_code_hit();
      portb_pin = CODE;
      step(1);
      portb_pin = IDLE_PB;
      step(1);
      chk("R3 not yet", 32'(cpu_rst), 32'd0);
      step(1);
      chk("R3 code resets", 32'(cpu_rst), 32'd1);
      chk("R9 cause code", 32'(rst_cause), 32'h4);
      step(3);
      chk("R6 hold code", 32'(cpu_rst), 32'd1);
      step(1);
      release_checks("code");
   endtask

   task automatic t_code_miss();
      portb_pin = 4'h4;
      step(6);
      chk("R3 near miss ignored", 32'(cpu_rst), 32'd0);
      portb_pin = 4'h0;
      step(6);
      chk("R3 zero ignored", 32'(cpu_rst), 32'd0);
      portb_pin = IDLE_PB;
      chk("R3 cause untouched", 32'(rst_cause), 32'h4);
   endtask

   task automatic t_wd_expire(input bit use_write);
      string tag;
      tag = use_write ? "R5 write no clear" : "R4 expire";
      if (use_write) begin
         wd_wr = 1'b1;
      end else begin
         wd_acc = 1'b0;
      end
      step(64);
      chk({tag, " before overflow"}, 32'(cpu_rst), 32'd0);
      step(1);
      chk({tag, " overflow resets"}, 32'(cpu_rst), 32'd1);
      chk("R9 cause wdog", 32'(rst_cause), 32'h8);
      wd_acc = 1'b1;
      wd_wr  = 1'b0;
      step(3);
      chk("R6 hold wdog", 32'(cpu_rst), 32'd1);
      step(1);
      release_checks(tag);
   endtask

   task automatic t_wd_read_clear();
      wd_acc = 1'b0;
      step(40);
      wd_acc = 1'b1;
      step(1);
      wd_acc = 1'b0;
      step(64);
      chk("R5 read restarted count", 32'(cpu_rst), 32'd0);
      step(1);
      chk("R5 overflow after clear", 32'(cpu_rst), 32'd1);
      wd_acc = 1'b1;
      step(4);
      release_checks("wd read");
   endtask

   task automatic t_por_again();
      step(1);
      por_n = 1'b0;
      #1;
      chk("R1 async assert", 32'(cpu_rst), 32'd1);
      chk("R9 por clears cause", 32'(rst_cause), 32'h1);
      step(2);
      por_n = 1'b1;
      step(5);
      chk("R1 held after por", 32'(cpu_rst), 32'd1);
      step(1);
      release_checks("por again");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      por_n     = 1'b0;
      ext_rst_n = 1'b1;
      portb_pin = IDLE_PB;
      wd_acc    = 1'b1;
      wd_wr     = 1'b0;
      cpu_ioctl = CTL_RUN;
      rom_data  = ROMBYTE;
      cpu_fetch = 1'b0;
      #1;
      t_power_on();
      t_pin_long();
      t_pin_short();
      t_code_hit();
      t_code_miss();
      t_wd_expire(1'b0);
      t_wd_expire(1'b1);
      t_wd_read_clear();
      t_por_again();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule